// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block takes a configuration stream that arrives one bit per clock and turns it into parallel writes to a configuration memory. A program request clears it and starts the load. It then hunts for a run of ones followed by a fixed 4-bit code, and captures a 24-bit length value. After that it unpacks a fixed number of data frames. Each frame is enclosed by a start bit and a group of stop bits. The framing is checked bit by bit, and each good frame is written as one word. The address starts at row zero and advances by one per frame.

A running count of the bits taken since the request is compared with the captured length. When the two agree and every frame has been written, a sticky length-reached flag tells the start-up logic that the load is complete. A framing fault sets a sticky error flag and stops all further writes until the next program request. The frame width, stop-bit count, frame count and header code are parameters.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, and in the cycle after a program request, `wr_en`, `frame_err` and `len_reached` are 0, and the bit counter is cleared. While no request has been made since reset, the stream is ignored and no write occurs.
- R2: The header is accepted only after at least 8 consecutive 1 bits, followed by the 4-bit code `PRE_CODE` (default 4'b0010, first bit received is the code's MSB, which must be 0). A 0 bit before 8 ones restarts the hunt. A code mismatch returns to hunting with an empty run of ones.
- R3: The 24 bits that follow the code are the length value, received MSB first.
- R4: Each frame is `1 + FRAME_BITS + STOP_BITS` bits long: one start bit of 0, then the data bits MSB first, then `STOP_BITS` bits of 1. Frames follow the length value back to back.
- R5: A well-framed frame produces a single-cycle `wr_en` in the cycle after its last stop bit is taken. `wr_data` is the data word, and `wr_addr` is 0 for the first frame and rises by one for each frame after it.
- R6: A start bit of 1 or any stop bit of 0 sets `frame_err` in the cycle after the offending bit. The flag stays set, and no write occurs, until the next program request.
- R7: The loader counts every bit taken since the request. Once all `NUM_FRAMES` frames have been written, `len_reached` rises right after the bit that brings this count to the loaded length, and it stays high until the next request. With a length of total stream bits minus 2, it rises after bit N-2 of an N-bit stream.
- R8: Bits after completion cause no write, and `len_reached` never rises once a framing error has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Program request: clears state and starts a new load |
| cfg_bit | input | 1 | Serial configuration stream bit |
| wr_en | output | 1 | Memory write strobe, one cycle per good frame |
| wr_addr | output | max(1,clog2(NUM_FRAMES)) | Memory row written |
| wr_data | output | FRAME_BITS | Data word of the frame |
| frame_err | output | 1 | Sticky framing-error flag |
| len_reached | output | 1 | Sticky flag: length count reached and all frames written |

## Verification
The loader is fed clean streams with random words and with all-zero, all-one and alternating words. The exact write cycles and data separate a correct frame split from an off-by-one in the start, data or stop fields. Prefixes with short runs of ones, a run of exactly seven ones and a wrong header code show whether the hunt accepts too early or fails to recover, because any misparse moves every later write. A bad start bit and bad stop bits at random positions check that the error fires on the offending bit and that no later row is written. An enlarged length value and a stream cut off mid-frame check that completion follows the loaded count rather than the frame count, and that a fresh request restarts cleanly from row zero.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  localparam int CFG_LEN_W    = 24;
  localparam int CFG_ONES_MIN = 8;
  localparam int CFG_CODE_W   = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HUNT,
    PH_LEN,
    PH_FRAMES,
    PH_TAIL,
    PH_DONE,
    PH_HALT
  } phase_t;

  // bits in one frame: start + data + stop
  function automatic int frame_span(input int data_w, input int stop_w);
    return 1 + data_w + stop_w;
  endfunction

  // running bit count after one more bit
  function automatic logic [CFG_LEN_W-1:0] next_count(input logic [CFG_LEN_W-1:0] c);
    return c + 1'b1;
  endfunction

endpackage

// File: rtl/cfg_hdr_hunt.sv
module cfg_hdr_hunt #(
  parameter int ONES_MIN = 8,
  parameter int CODE_W   = 4,
  parameter logic [CODE_W-1:0] CODE = 4'b0010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  input  logic bit_in,
  output logic found
);
  localparam int RW  = $clog2(ONES_MIN + 1);
  localparam int CIW = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  logic [RW-1:0]     run_cnt;
  logic              in_code;
  logic [CODE_W-1:0] code_sr;
  logic [CIW-1:0]    code_idx;

  always_comb
    found = en && in_code && (code_idx == CIW'(CODE_W - 1)) &&
            ({code_sr[CODE_W-2:0], bit_in} == CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      in_code  <= 1'b0;
      code_sr  <= '0;
      code_idx <= '0;
    end else if (restart) begin
      run_cnt  <= '0;
      in_code  <= 1'b0;
      code_sr  <= '0;
      code_idx <= '0;
    end else if (en) begin
      if (!in_code) begin
        if (bit_in) begin
          if (run_cnt != RW'(ONES_MIN)) run_cnt <= run_cnt + 1'b1;
        end else if (run_cnt == RW'(ONES_MIN)) begin
          in_code  <= 1'b1;
          code_sr  <= '0;
          code_idx <= CIW'(1);
          run_cnt  <= '0;
        end else begin
          run_cnt <= '0;
        end
      end else begin
        code_sr <= {code_sr[CODE_W-2:0], bit_in};
        if (code_idx == CIW'(CODE_W - 1)) begin
          in_code  <= 1'b0;
          code_idx <= '0;
          run_cnt  <= '0;
        end else begin
          code_idx <= code_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_frame_unpack.sv
module cfg_frame_unpack
  import cfg_ld_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int STOP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              en,
  input  logic              bit_in,
  output logic              frame_good,
  output logic              frame_bad,
  output logic [DATA_W-1:0] word
);
  localparam int SPAN = frame_span(DATA_W, STOP_W);
  localparam int PW   = $clog2(SPAN);

  logic [PW-1:0]     pos;
  logic [DATA_W-1:0] sr;
  logic              at_start, at_data, at_stop, at_last;

  always_comb begin
    at_start   = (pos == '0);
    at_data    = !at_start && (pos <= PW'(DATA_W));
    at_stop    = (pos > PW'(DATA_W));
    at_last    = (pos == PW'(SPAN - 1));
    frame_bad  = en && ((at_start && bit_in) || (at_stop && !bit_in));
    frame_good = en && at_last && bit_in;
    word       = sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      sr  <= '0;
    end else if (restart) begin
      pos <= '0;
      sr  <= '0;
    end else if (en) begin
      if (frame_bad || at_last) pos <= '0;
      else                      pos <= pos + 1'b1;
      if (at_data) sr <= {sr[DATA_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/cfg_len_track.sv
module cfg_len_track
  import cfg_ld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic count_en,
  input  logic shift_en,
  input  logic bit_in,
  output logic match
);
  logic [CFG_LEN_W-1:0] cnt;
  logic [CFG_LEN_W-1:0] len_q;

  always_comb match = (next_count(cnt) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_q <= '0;
    end else if (restart) begin
      cnt   <= '0;
      len_q <= '0;
    end else begin
      if (count_en) cnt   <= next_count(cnt);
      if (shift_en) len_q <= {len_q[CFG_LEN_W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_ld_pkg::*;
#(
  parameter int FRAME_BITS = 12,
  parameter int STOP_BITS  = 3,
  parameter int NUM_FRAMES = 8,
  parameter logic [3:0] PRE_CODE = 4'b0010,
  localparam int ADDR_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_req,
  input  logic                  cfg_bit,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [FRAME_BITS-1:0] wr_data,
  output logic                  frame_err,
  output logic                  len_reached
);
  localparam int FC_W = $clog2(NUM_FRAMES + 1);
  localparam int LI_W = $clog2(CFG_LEN_W);

  phase_t          phase;
  logic [LI_W-1:0] len_idx;
  logic [FC_W-1:0] frames;

  // named internal events
  logic                  hdr_found;
  logic                  frame_good;
  logic                  frame_bad;
  logic                  len_match;
  logic                  counting;
  logic [FRAME_BITS-1:0] frame_word;

  always_comb
    counting = (phase == PH_HUNT) || (phase == PH_LEN) ||
               (phase == PH_FRAMES) || (phase == PH_TAIL);

  cfg_hdr_hunt #(
    .ONES_MIN (CFG_ONES_MIN),
    .CODE_W   (CFG_CODE_W),
    .CODE     (PRE_CODE)
  ) u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (prog_req),
    .en      (phase == PH_HUNT),
    .bit_in  (cfg_bit),
    .found   (hdr_found)
  );

  cfg_len_track u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (prog_req),
    .count_en (counting),
    .shift_en (phase == PH_LEN),
    .bit_in   (cfg_bit),
    .match    (len_match)
  );

  cfg_frame_unpack #(
    .DATA_W (FRAME_BITS),
    .STOP_W (STOP_BITS)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (prog_req),
    .en         (phase == PH_FRAMES),
    .bit_in     (cfg_bit),
    .frame_good (frame_good),
    .frame_bad  (frame_bad),
    .word       (frame_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      len_idx     <= '0;
      frames      <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      frame_err   <= 1'b0;
      len_reached <= 1'b0;
    end else if (prog_req) begin
      phase       <= PH_HUNT;
      len_idx     <= '0;
      frames      <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      frame_err   <= 1'b0;
      len_reached <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      unique case (phase)
        PH_HUNT: if (hdr_found) phase <= PH_LEN;
        PH_LEN: begin
          len_idx <= len_idx + 1'b1;
          if (len_idx == LI_W'(CFG_LEN_W - 1)) phase <= PH_FRAMES;
        end
        PH_FRAMES: begin
          if (frame_bad) begin
            frame_err <= 1'b1;
            phase     <= PH_HALT;
          end else if (frame_good) begin
            wr_en   <= 1'b1;
            wr_data <= frame_word;
            wr_addr <= frames[ADDR_W-1:0];
            frames  <= frames + 1'b1;
            if (frames == FC_W'(NUM_FRAMES - 1)) phase <= PH_TAIL;
          end
        end
        PH_TAIL: if (len_match) begin
          len_reached <= 1'b1;
          phase       <= PH_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_req,
  input logic wr_en,
  input logic frame_err,
  input logic len_reached,
  input logic hdr_found,
  input logic frame_good,
  input logic frame_bad
);
  assert_req_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> (!frame_err && !len_reached && !wr_en));

  assert_hdr_not_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_found && (frame_good || frame_bad)));

  assert_frame_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_good, frame_bad}));

  assert_good_frame_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_good && !prog_req) |=> wr_en);

  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_bad_frame_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bad && !prog_req) |=> (frame_err && !wr_en));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !prog_req) |=> frame_err);

  assert_no_write_with_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !wr_en);

  assert_len_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_reached && !prog_req) |=> len_reached);

  assert_len_excludes_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(len_reached && frame_err));

  assert_no_write_after_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_reached |-> !wr_en);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_req    (prog_req),
  .wr_en       (wr_en),
  .frame_err   (frame_err),
  .len_reached (len_reached),
  .hdr_found   (hdr_found),
  .frame_good  (frame_good),
  .frame_bad   (frame_bad)
);

// File: tb/cfg_stream_loader_bench.sv
`timescale 1ns/1ps
module cfg_stream_loader_bench;
  localparam int FB = 12;
  localparam int SB = 3;
  localparam int NF = 8;
  localparam int F  = 1 + FB + SB;
  localparam int AW = $clog2(NF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_req = 1'b0;
  logic cfg_bit = 1'b1;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [FB-1:0] wr_data;
  logic frame_err;
  logic len_reached;

  int checks = 0;
  int fails  = 0;

  bit sq[$];
  int hdr_end;
  int len_pos;
  int len_val;
  logic [FB-1:0] exp_data [NF];

  always #10 clk = ~clk;

  cfg_stream_loader #(
    .FRAME_BITS (FB),
    .STOP_BITS  (SB),
    .NUM_FRAMES (NF)
  ) u_cfg_stream_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_req    (prog_req),
    .cfg_bit     (cfg_bit),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .frame_err   (frame_err),
    .len_reached (len_reached)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic add_ones(input int n);
    for (int i = 0; i < n; i++) sq.push_back(1'b1);
  endtask

  task automatic add_bits(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) sq.push_back(v[i]);
  endtask

  task automatic add_header(input int lead, input logic [3:0] code);
    add_ones(lead);
    add_bits({28'd0, code}, 4);
    len_pos = sq.size();
    add_bits(32'd0, 24);
    hdr_end = sq.size();
  endtask

  function automatic logic [FB-1:0] pick_word(input int pattern);
    case (pattern)
      1: return '0;
      2: return '1;
      3: return {(FB/2){2'b10}};
      default: return FB'($urandom());
    endcase
  endfunction

  // bad_pos: -1 none, 0 start bit, j in 1..SB stop bit j
  task automatic add_frames(input int pattern, input int bad_frame, input int bad_pos);
    for (int f = 0; f < NF; f++) begin
      logic [FB-1:0] w;
      w = pick_word(pattern);
      exp_data[f] = w;
      sq.push_back((f == bad_frame && bad_pos == 0) ? 1'b1 : 1'b0);
      add_bits({{(32-FB){1'b0}}, w}, FB);
      for (int j = 1; j <= SB; j++)
        sq.push_back((f == bad_frame && bad_pos == j) ? 1'b0 : 1'b1);
    end
  endtask

  task automatic finish_stream(input int extra_len, input int idle);
    add_ones(4);
    while (sq.size() % 8 != 0) sq.push_back(1'b1);
    len_val = sq.size() - 2 + extra_len;
    for (int i = 0; i < 24; i++) sq[len_pos + i] = len_val[23 - i];
    add_ones(idle);
  endtask

  function automatic int err_cycle(input int f, input int pos);
    return hdr_end + f * F + ((pos == 0) ? 0 : FB + pos) + 1;
  endfunction

  // drives the stream after a request; limit < size means a cut-off run
  task automatic run_stream(input int n_good, input int exp_len, input int exp_err,
                            input string tag, input int limit);
    int wr_seen = 0;
    int len_first = 0;
    int err_first = 0;
    int wr_after_len = 0;
    @(negedge clk);
    prog_req = 1'b1;
    cfg_bit  = 1'b1;
    @(negedge clk);
    prog_req = 1'b0;
    check({wr_en, frame_err, len_reached} == 3'b000, "R1 clear after request",
          {wr_en, frame_err, len_reached}, 0);
    for (int k = 0; k < limit; k++) begin
      int cyc;
      cfg_bit = sq[k];
      @(negedge clk);
      cyc = k + 1;
      if (wr_en) begin
        if (len_reached) wr_after_len++;
        if (wr_seen < n_good) begin
          check(wr_data == exp_data[wr_seen], "R5 write data", wr_data, exp_data[wr_seen]);
          check(wr_addr == AW'(wr_seen), "R5 write address", wr_addr, wr_seen);
          check(cyc == hdr_end + (wr_seen + 1) * F, "R4 write cycle", cyc,
                hdr_end + (wr_seen + 1) * F);
        end
        wr_seen++;
      end
      if (len_reached && len_first == 0) len_first = cyc;
      if (frame_err && err_first == 0) err_first = cyc;
    end
    cfg_bit = 1'b1;
    if (limit == sq.size()) begin
      check(wr_seen == n_good, tag, wr_seen, n_good);
      check(len_first == exp_len, "R7 length reached cycle", len_first, exp_len);
      check(err_first == exp_err, "R6 error cycle", err_first, exp_err);
      check(wr_after_len == 0, "R8 writes after completion", wr_after_len, 0);
      if (exp_len != 0) check(len_reached == 1'b1, "R8 completion held", len_reached, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog: got %0d cycles expected fewer", 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int wr_idle;
    void'($urandom(32'd31337));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R1 reset wr_en", wr_en, 0);
    check(frame_err == 1'b0, "R1 reset frame_err", frame_err, 0);
    check(len_reached == 1'b0, "R1 reset len_reached", len_reached, 0);
    rst_n = 1'b1;

    // R1: a valid stream without a request is ignored
    sq.delete();
    add_header(8, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(0, 4);
    wr_idle = 0;
    for (int k = 0; k < sq.size(); k++) begin
      cfg_bit = sq[k];
      @(negedge clk);
      if (wr_en || len_reached) wr_idle++;
    end
    check(wr_idle == 0, "R1 stream ignored before request", wr_idle, 0);

    // nominal stream, random words
    sq.delete();
    add_header(8, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(0, 6);
    run_stream(NF, len_val, 0, "R5 write count", sq.size());

    // word corner patterns
    for (int p = 1; p <= 3; p++) begin
      sq.delete();
      add_header(8, 4'b0010);
      add_frames(p, -1, -1);
      finish_stream(0, 6);
      run_stream(NF, len_val, 0, "R4 write count pattern", sq.size());
    end

    // random long leads and short false runs before the preamble (R2)
    for (int r = 0; r < 4; r++) begin
      sq.delete();
      add_ones(1 + $urandom_range(0, 6));
      sq.push_back(1'b0);
      add_header(8 + $urandom_range(0, 12), 4'b0010);
      add_frames(0, -1, -1);
      finish_stream(0, 6);
      run_stream(NF, len_val, 0, "R2 write count after false run", sq.size());
    end

    // wrong header code, then a correct header (R2)
    sq.delete();
    add_ones(10);
    add_bits(32'b0110, 4);
    add_header(8, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(0, 6);
    run_stream(NF, len_val, 0, "R2 write count after wrong code", sq.size());

    // seven ones then the code must not lock (R2)
    sq.delete();
    add_ones(7);
    add_bits(32'b0010, 4);
    add_header(9, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(0, 6);
    run_stream(NF, len_val, 0, "R2 write count after seven ones", sq.size());

    // length larger than stream: completion follows the loaded value (R3)
    sq.delete();
    add_header(8, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(9, 14);
    run_stream(NF, len_val, 0, "R3 write count long length", sq.size());

    // bad start bit in a random frame (R6)
    for (int r = 0; r < 2; r++) begin
      int bf;
      bf = $urandom_range(1, NF - 1);
      sq.delete();
      add_header(8, 4'b0010);
      add_frames(0, bf, 0);
      finish_stream(0, 6);
      run_stream(bf, 0, err_cycle(bf, 0), "R6 writes before bad start", sq.size());
    end

    // bad stop bit in frame 0 (R6)
    begin
      int bp;
      bp = $urandom_range(1, SB);
      sq.delete();
      add_header(8, 4'b0010);
      add_frames(0, 0, bp);
      finish_stream(0, 6);
      run_stream(0, 0, err_cycle(0, bp), "R6 writes before bad stop", sq.size());
    end

    // bad last stop bit of the last frame (R6, R8)
    sq.delete();
    add_header(8, 4'b0010);
    add_frames(0, NF - 1, SB);
    finish_stream(0, 6);
    run_stream(NF - 1, 0, err_cycle(NF - 1, SB), "R8 writes before last bad stop", sq.size());

    // cut off mid-frame, then a full restart (R1)
    sq.delete();
    add_header(8, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(0, 6);
    run_stream(NF, len_val, 0, "R1 cut run", hdr_end + 2 * F + 5);
    sq.delete();
    add_header(11, 4'b0010);
    add_frames(0, -1, -1);
    finish_stream(0, 6);
    run_stream(NF, len_val, 0, "R1 write count after restart", sq.size());

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule